// File: doc/BRIEF.md
# Dual Snapshot Counter with Byte Readout

The block holds two independent 16-bit up-counters, called A and B, running in one system clock domain. Each counter advances on the rising edge of its own count strobe. Counter B also has an active-low count enable. A shared capture strobe freezes both counts at the same moment into two holding registers. Software-free logic, such as a slow host or a test harness, then reads these registers out one byte at a time through an 8-bit port. Four active-low byte selects choose which byte appears on that port.

Counter A reports, through an active-low carry flag, when it sits at its top value. If that flag is wired into counter B's enable and both count strobes are tied together, the two counters form a single 32-bit counter, with B as the upper half. A clear input acts asynchronously on the two counters only; the holding registers keep their last snapshot.

The readout port is level-selected and purely combinational from the holding registers. It has no valid/ready handshake and no back-pressure: a byte is present for as long as its select is held low. All strobes are treated as synchronous to `clk` and are edge-detected inside the block.

Top module: `snap_counter`

## Requirements
- R1: Counter A advances by exactly one in the cycle in which `cnt_a_stb` is first seen high. A strobe held high for several cycles counts only once.
- R2: Each counter wraps from 0xFFFF to 0x0000 on the next count.
- R3: Counter B advances by one on a rising edge of `cnt_b_stb` only when `b_en_n` is low in that same cycle. Otherwise it keeps its value.
- R4: While `clr_n` is low, both counters are forced to zero without waiting for a clock. The holding registers keep their contents.
- R5: `carry_a_n` is low exactly while counter A holds 0xFFFF.
- R6: If `b_en_n` is driven from `carry_a_n` and both count strobes are driven by one signal, {B, A} counts as one 32-bit value, and B advances when A wraps.
- R7: A rising edge of `cap_stb` loads counter A into holding register A and counter B into holding register B in the same cycle. If a count edge falls in that cycle, the value captured is the one from before the increment.
- R8: With exactly one select low, `rd_oe` is high and `rd_data` carries the selected byte. The mapping is: `sel_n[0]` gives A bits 7:0, `sel_n[1]` gives A bits 15:8, `sel_n[2]` gives B bits 7:0, and `sel_n[3]` gives B bits 15:8.
- R9: With all selects high, `rd_oe`, `sel_err` and `rd_data` are all zero.
- R10: With two or more selects low, `sel_err` is high, `rd_oe` is low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset (all state) |
| clr_n | input | 1 | Asynchronous active-low clear of both counters |
| cnt_a_stb | input | 1 | Count strobe of counter A (rising edge counts) |
| cnt_b_stb | input | 1 | Count strobe of counter B (rising edge counts) |
| b_en_n | input | 1 | Active-low count enable of counter B |
| cap_stb | input | 1 | Capture strobe (rising edge snapshots both counters) |
| sel_n | input | 4 | Active-low byte selects |
| rd_data | output | 8 | Selected byte, zero when not driven |
| rd_oe | output | 1 | High when exactly one select is low |
| sel_err | output | 1 | High when two or more selects are low |
| carry_a_n | output | 1 | Low while counter A is 0xFFFF |

## Verification
A count edge and a capture edge can land in the same clock cycle. They must then agree on which counter value the snapshot holds. The bench provokes this by raising `cnt_a_stb` and `cap_stb` at the same falling edge. It then reads holding register A back through the byte port and expects the pre-increment value. It follows with a second capture and expects the incremented value. The same cycle-sharing is exercised for counter B's enable and strobe, and the cascade puts A's wrap and B's increment in one edge.

// File: rtl/snapctr_pkg.sv
package snapctr_pkg;
  // Byte lanes of the readout port, in select-bit order.
  typedef enum logic [1:0] {
    LANE_A_LO = 2'd0,
    LANE_A_HI = 2'd1,
    LANE_B_LO = 2'd2,
    LANE_B_HI = 2'd3
  } lane_e;

  localparam int unsigned DEF_CNT_W  = 16;
  localparam int unsigned DEF_BYTE_W = 8;
endpackage

// File: rtl/snapctr_edge.sv
module snapctr_edge #(
  parameter int unsigned N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/snapctr_count.sv
module snapctr_count #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         step,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  // R1 / R2: one count per step, wrapping at the top value
  p_step_r1: assert property (@(posedge clk) disable iff (!arst_n)
    step |=> cnt == W'($past(cnt) + 1'b1));

  // R3: no step, no change
  p_still_r3: assert property (@(posedge clk) disable iff (!arst_n)
    !step |=> $stable(cnt));
endmodule

// File: rtl/snapctr_readout.sv
module snapctr_readout
  import snapctr_pkg::*;
#(
  parameter int unsigned W      = DEF_CNT_W,
  parameter int unsigned BYTE_W = DEF_BYTE_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [W-1:0]                     hold_lo,
  input  logic [W-1:0]                     hold_hi,
  input  logic [2*(W/BYTE_W)-1:0]          sel_n,
  output logic [BYTE_W-1:0]                data,
  output logic                             oe,
  output logic                             err
);
  localparam int unsigned NB   = W / BYTE_W;
  localparam int unsigned NSEL = 2 * NB;

  logic [2*W-1:0]               flat;
  logic [NSEL-1:0]              act;
  logic [NSEL-1:0][BYTE_W-1:0]  gated;
  logic [BYTE_W-1:0]            merged;

  assign flat = {hold_hi, hold_lo};
  assign act  = ~sel_n;

  for (genvar i = 0; i < NSEL; i++) begin : g_lane
    assign gated[i] = act[i] ? flat[i*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < NSEL; i++) merged = merged | gated[i];
    oe   = ($countones(act) == 1);
    err  = ($countones(act) > 1);
    data = oe ? merged : '0;
  end

  // R8: output enable only with a single active select
  p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> $countones(sel_n) == NSEL - 1);

  // R9: idle port is silent
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&sel_n) |-> (!oe && !err && data == '0));

  // R10: conflicting selects mute the port
  p_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!oe && data == '0));
endmodule

// File: rtl/snap_counter.sv
module snap_counter
  import snapctr_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned BYTE_W = DEF_BYTE_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr_n,
  input  logic                           cnt_a_stb,
  input  logic                           cnt_b_stb,
  input  logic                           b_en_n,
  input  logic                           cap_stb,
  input  logic [2*(CNT_W/BYTE_W)-1:0]    sel_n,
  output logic [BYTE_W-1:0]              rd_data,
  output logic                           rd_oe,
  output logic                           sel_err,
  output logic                           carry_a_n
);
  logic [2:0]       rise;
  logic             step_a, step_b, cap_rise;
  logic             cnt_arst_n;
  logic [CNT_W-1:0] cnt_a, cnt_b, hold_a, hold_b;

  snapctr_edge #(.N(3)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({cap_stb, cnt_b_stb, cnt_a_stb}),
    .rise  (rise)
  );

  assign step_a   = rise[0];
  assign step_b   = rise[1] & ~b_en_n;
  assign cap_rise = rise[2];

  // counters see both the system reset and the clear
  assign cnt_arst_n = rst_n & clr_n;

  snapctr_count #(.W(CNT_W)) u_cnt_a (
    .clk (clk), .arst_n (cnt_arst_n), .step (step_a), .cnt (cnt_a)
  );

  snapctr_count #(.W(CNT_W)) u_cnt_b (
    .clk (clk), .arst_n (cnt_arst_n), .step (step_b), .cnt (cnt_b)
  );

  // snapshot registers: untouched by the counter clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a <= '0;
      hold_b <= '0;
    end else if (cap_rise) begin
      hold_a <= cnt_a;
      hold_b <= cnt_b;
    end
  end

  assign carry_a_n = ~(&cnt_a);

  snapctr_readout #(.W(CNT_W), .BYTE_W(BYTE_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_lo (hold_a),
    .hold_hi (hold_b),
    .sel_n   (sel_n),
    .data    (rd_data),
    .oe      (rd_oe),
    .err     (sel_err)
  );

  // R7: capture takes the value present before any same-cycle increment
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> (hold_a == $past(cnt_a) && hold_b == $past(cnt_b)));

  // R4: snapshot holds when no capture edge
  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_rise |=> ($stable(hold_a) && $stable(hold_b)));
endmodule

// File: tb/snap_counter_tb.sv
module snap_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n, clr_n, a_stb, b_stb_r, b_en_r, cap_stb, chain;
  logic [3:0] sel_n;
  logic       cnt_b_stb, b_en_n;
  logic [7:0] rd_data;
  logic       rd_oe, sel_err, carry_a_n;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  assign cnt_b_stb = chain ? a_stb     : b_stb_r;
  assign b_en_n    = chain ? carry_a_n : b_en_r;

  snap_counter u_dut (
    .clk (clk), .rst_n (rst_n), .clr_n (clr_n),
    .cnt_a_stb (a_stb), .cnt_b_stb (cnt_b_stb), .b_en_n (b_en_n),
    .cap_stb (cap_stb), .sel_n (sel_n),
    .rd_data (rd_data), .rd_oe (rd_oe), .sel_err (sel_err),
    .carry_a_n (carry_a_n)
  );

  // {sel_n, data, oe, err} with A=0x0305 and B=0x0A07 captured (R8, R9, R10)
  localparam logic [13:0] VEC [16] = '{
    {4'b1111, 8'h00, 1'b0, 1'b0},
    {4'b1110, 8'h05, 1'b1, 1'b0},
    {4'b1101, 8'h03, 1'b1, 1'b0},
    {4'b1011, 8'h07, 1'b1, 1'b0},
    {4'b0111, 8'h0A, 1'b1, 1'b0},
    {4'b1100, 8'h00, 1'b0, 1'b1},
    {4'b1010, 8'h00, 1'b0, 1'b1},
    {4'b1001, 8'h00, 1'b0, 1'b1},
    {4'b0110, 8'h00, 1'b0, 1'b1},
    {4'b0101, 8'h00, 1'b0, 1'b1},
    {4'b0011, 8'h00, 1'b0, 1'b1},
    {4'b1000, 8'h00, 1'b0, 1'b1},
    {4'b0100, 8'h00, 1'b0, 1'b1},
    {4'b0010, 8'h00, 1'b0, 1'b1},
    {4'b0001, 8'h00, 1'b0, 1'b1},
    {4'b0000, 8'h00, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] s, input logic [7:0] ed, input logic eoe,
                    input logic eerr, input string req);
    @(negedge clk);
    sel_n = s;
    #1;
    chk({req, " data"}, 32'(rd_data), 32'(ed));
    chk({req, " oe"},   32'(rd_oe),   32'(eoe));
    chk({req, " err"},  32'(sel_err), 32'(eerr));
  endtask

  task automatic pulse_a(input int n);
    repeat (n) begin
      @(negedge clk) a_stb = 1'b1;
      @(negedge clk) a_stb = 1'b0;
    end
  endtask

  task automatic pulse_b(input int n);
    repeat (n) begin
      @(negedge clk) b_stb_r = 1'b1;
      @(negedge clk) b_stb_r = 1'b0;
    end
  endtask

  task automatic capture();
    @(negedge clk) cap_stb = 1'b1;
    @(negedge clk) cap_stb = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 0; clr_n = 1; a_stb = 0; b_stb_r = 0; b_en_r = 1;
    cap_stb = 0; chain = 0; sel_n = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state (R9, R5)
    rd(4'b1111, 8'h00, 1'b0, 1'b0, "R9 reset idle");
    chk("R5 reset carry", 32'(carry_a_n), 32'd1);
    capture();
    rd(4'b1110, 8'h00, 1'b1, 1'b0, "R8 reset A lo");

    // build A=0x0305, B=0x0A07 (R1, R3)
    pulse_a(773);
    b_en_r = 0;
    pulse_b(2567);
    capture();
    for (int i = 0; i < 16; i++)
      rd(VEC[i][13:10], VEC[i][9:2], VEC[i][1], VEC[i][0], "R8/R9/R10 table");

    // same-cycle count and capture (R7)
    @(negedge clk) begin a_stb = 1; cap_stb = 1; end
    @(negedge clk) begin a_stb = 0; cap_stb = 0; end
    rd(4'b1110, 8'h05, 1'b1, 1'b0, "R7 pre-increment capture");
    capture();
    rd(4'b1110, 8'h06, 1'b1, 1'b0, "R7 later capture");

    // strobe held high counts once (R1)
    @(negedge clk) a_stb = 1;
    repeat (5) @(negedge clk);
    a_stb = 0;
    capture();
    rd(4'b1110, 8'h07, 1'b1, 1'b0, "R1 held strobe");

    // B enable gating (R3)
    b_en_r = 1;
    pulse_b(3);
    capture();
    rd(4'b1011, 8'h07, 1'b1, 1'b0, "R3 disabled B");
    b_en_r = 0;
    pulse_b(1);
    capture();
    rd(4'b1011, 8'h08, 1'b1, 1'b0, "R3 enabled B");

    // clear keeps snapshot, zeroes counters (R4)
    @(negedge clk) clr_n = 0;
    #1;
    rd(4'b0111, 8'h0A, 1'b1, 1'b0, "R4 snapshot kept");
    @(negedge clk) clr_n = 1;
    capture();
    rd(4'b1110, 8'h00, 1'b1, 1'b0, "R4 A cleared");
    rd(4'b1011, 8'h00, 1'b1, 1'b0, "R4 B cleared");

    // 32-bit cascade (R5, R6, R2)
    chain = 1;
    pulse_a(65535);
    #1;
    chk("R5 carry at top", 32'(carry_a_n), 32'd0);
    capture();
    rd(4'b1110, 8'hFF, 1'b1, 1'b0, "R6 A lo top");
    rd(4'b1101, 8'hFF, 1'b1, 1'b0, "R6 A hi top");
    rd(4'b1011, 8'h00, 1'b1, 1'b0, "R6 B before wrap");
    pulse_a(1);
    #1;
    chk("R5 carry after wrap", 32'(carry_a_n), 32'd1);
    capture();
    rd(4'b1110, 8'h00, 1'b1, 1'b0, "R2 A lo wrapped");
    rd(4'b1101, 8'h00, 1'b1, 1'b0, "R2 A hi wrapped");
    rd(4'b1011, 8'h01, 1'b1, 1'b0, "R6 B carried");
    rd(4'b0111, 8'h00, 1'b1, 1'b0, "R6 B hi");
    pulse_a(1);
    capture();
    rd(4'b1110, 8'h01, 1'b1, 1'b0, "R6 A after wrap");
    rd(4'b1011, 8'h01, 1'b1, 1'b0, "R6 B steady");

    finish_run();
  end
endmodule